// File: doc/BRIEF.md
# Vector Extension Prefix Parser

This block sits in an instruction decoder running in 64-bit mode. It takes the bytes of a candidate vector extension prefix, which come right before the opcode byte. It also takes flags that say which other prefixes came earlier in the instruction. When the leading byte is the three-byte escape (C4h) or the two-byte escape (C5h), the parser pulls the packed fields out of the following bytes. It undoes the inverted storage of several of those fields and reports the following normalised fields:

- the register-extension bits
- the opcode map number
- the operand-width bit
- the extra source register number
- the vector length
- the implied SIMD prefix code

It also gives the length of the prefix and an undefined-opcode flag. The flag is raised when the combination of prefix bytes and earlier prefixes is illegal.

One set of bytes is accepted on each cycle that carries a valid strobe. The results appear on registered outputs one clock later. When the valid strobe is low, the last result stays on the outputs.

Top module: `vexp_parser`

## Requirements
- R1: During and right after a synchronous reset, every output is 0: out_valid, out_plen, out_ud, and all the decode fields.
- R2: out_valid in a given cycle equals in_valid from the cycle before. The result for bytes sampled on one clock edge appears after that same edge.
- R3: When in_valid is high and in_b0 is neither C4h nor C5h, out_plen is 0, out_ud is 0 and every decode field is 0, whatever the prefix flags are.
- R4: For in_b0 = C5h: out_plen is 2 and out_r = NOT in_b1[7]. out_x and out_b are 0, out_map is 1 (the 0F map) and out_w is 0.
- R5: For in_b0 = C5h: out_vreg = NOT in_b1[6:3], out_l = in_b1[2] and out_pp = in_b1[1:0]. in_b2 has no effect on any output.
- R6: For in_b0 = C4h: out_plen is 3. out_r, out_x and out_b are NOT in_b1[7], NOT in_b1[6] and NOT in_b1[5], and out_map = in_b1[4:0].
- R7: For in_b0 = C4h: out_w = in_b2[7], out_vreg = NOT in_b2[6:3], out_l = in_b2[2] (0 = 128-bit, 1 = 256-bit) and out_pp = in_b2[1:0]. The pp code is 00 = none, 01 = 66h, 10 = F3h, 11 = F2h.
- R8: For in_b0 = C4h, a map value of 0 or of 4 and above sets out_ud. Map values 1 to 3 leave it clear when no earlier prefix is flagged.
- R9: With C4h or C5h, any of pre_66, pre_rep, pre_lock or pre_rex being high sets out_ud. With both escapes, out_ud is clear when none of those flags is high and the map is legal.
- R10: While in_valid is low, out_plen, out_ud and all decode fields keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Prefix bytes are present this cycle |
| in_b0 | input | 8 | Candidate escape byte |
| in_b1 | input | 8 | First byte after the escape |
| in_b2 | input | 8 | Second byte after the escape (three-byte form only) |
| pre_66 | input | 1 | An operand-size prefix came earlier |
| pre_rep | input | 1 | An F2h or F3h prefix came earlier |
| pre_lock | input | 1 | A lock prefix came earlier |
| pre_rex | input | 1 | A register-extension (40h-4Fh) prefix came earlier |
| out_valid | output | 1 | Result is valid this cycle |
| out_plen | output | 2 | Prefix length in bytes: 0, 2 or 3 |
| out_r | output | 1 | True extension bit of the register field |
| out_x | output | 1 | True extension bit of the index field |
| out_b | output | 1 | True extension bit of the base or r/m field |
| out_map | output | 5 | Opcode map number |
| out_w | output | 1 | Operand-width bit |
| out_vreg | output | 4 | Extra source register number |
| out_l | output | 1 | Vector length, 0 = 128-bit, 1 = 256-bit |
| out_pp | output | 2 | Implied SIMD prefix code |
| out_ud | output | 1 | Undefined-opcode fault |

## Verification
The bench first runs payload bytes of all-ones and all-zeros through both escapes. This shows whether each inverted field is complemented and whether the non-inverted fields are left alone. It then steps every map value from 0 to 31 behind C4h, so an off-by-one error at the reserved value 0 or at the top legal value 3 is caught. Each earlier-prefix flag is raised on its own with C4h, with C5h and with an ordinary opcode byte, which separates faults that are tied to the escape from faults that are raised on every byte. Finally, mixed cycles of random bytes, with in_valid toggling, test that results are held and that in_b2 is ignored in the two-byte form.

// File: rtl/vexp_pkg.sv
package vexp_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 4;
  localparam int MAP_W  = 5;

  typedef enum logic [1:0] {
    PFX_NONE  = 2'd0,
    PFX_SHORT = 2'd2,
    PFX_LONG  = 2'd3
  } pfx_kind_e;

  typedef struct packed {
    logic             r;
    logic             x;
    logic             b;
    logic [MAP_W-1:0] map;
    logic             w;
    logic [REG_W-1:0] vreg;
    logic             l;
    logic [1:0]       pp;
  } vexp_fields_t;
endpackage

// File: rtl/vexp_field_decode.sv
module vexp_field_decode
  import vexp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ESC_SHORT = 8'hC5,
  parameter logic [BYTE_W-1:0] ESC_LONG  = 8'hC4
) (
  input  logic [BYTE_W-1:0] b0,
  input  logic [BYTE_W-1:0] b1,
  input  logic [BYTE_W-1:0] b2,
  output pfx_kind_e         kind,
  output vexp_fields_t      fields
);
  localparam int VREG_LSB = 3;

  logic [REG_W-1:0] vreg_raw;

  always_comb begin
    kind = PFX_NONE;
    if (b0 == ESC_LONG)       kind = PFX_LONG;
    else if (b0 == ESC_SHORT) kind = PFX_SHORT;
  end

  // The byte that carries vvvv/L/pp: b1 for the short form, b2 for the long one.
  always_comb begin
    vreg_raw = (kind == PFX_LONG) ? b2[VREG_LSB +: REG_W] : b1[VREG_LSB +: REG_W];
  end

  always_comb begin
    fields = '0;
    unique case (kind)
      PFX_SHORT: begin
        fields.r    = ~b1[7];
        fields.map  = MAP_W'(1);
        fields.vreg = ~vreg_raw;
        fields.l    = b1[2];
        fields.pp   = b1[1:0];
      end
      PFX_LONG: begin
        fields.r    = ~b1[7];
        fields.x    = ~b1[6];
        fields.b    = ~b1[5];
        fields.map  = b1[MAP_W-1:0];
        fields.w    = b2[7];
        fields.vreg = ~vreg_raw;
        fields.l    = b2[2];
        fields.pp   = b2[1:0];
      end
      default: fields = '0;
    endcase
  end
endmodule

// File: rtl/vexp_fault_check.sv
module vexp_fault_check
  import vexp_pkg::*;
#(
  parameter int MAP_LAST = 3
) (
  input  pfx_kind_e        kind,
  input  logic [MAP_W-1:0] map,
  input  logic             pre_66,
  input  logic             pre_rep,
  input  logic             pre_lock,
  input  logic             pre_rex,
  output logic             ud
);
  logic any_prior;
  logic map_bad;

  always_comb begin
    any_prior = pre_66 | pre_rep | pre_lock | pre_rex;
    map_bad   = (map == '0) || (int'(map) > MAP_LAST);
    ud        = 1'b0;
    if (kind != PFX_NONE) ud = any_prior;
    if (kind == PFX_LONG) ud = ud | map_bad;
  end
endmodule

// File: rtl/vexp_parser.sv
module vexp_parser
  import vexp_pkg::*;
#(
  parameter logic [7:0] ESC_SHORT = 8'hC5,
  parameter logic [7:0] ESC_LONG  = 8'hC4,
  parameter int         MAP_LAST  = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_b0,
  input  logic [7:0] in_b1,
  input  logic [7:0] in_b2,
  input  logic       pre_66,
  input  logic       pre_rep,
  input  logic       pre_lock,
  input  logic       pre_rex,
  output logic       out_valid,
  output logic [1:0] out_plen,
  output logic       out_r,
  output logic       out_x,
  output logic       out_b,
  output logic [4:0] out_map,
  output logic       out_w,
  output logic [3:0] out_vreg,
  output logic       out_l,
  output logic [1:0] out_pp,
  output logic       out_ud
);
  pfx_kind_e    dec_kind;
  vexp_fields_t dec_fields;
  logic         dec_ud;

  logic         valid_q;
  logic [1:0]   plen_q;
  vexp_fields_t fields_q;
  logic         ud_q;

  vexp_field_decode #(
    .ESC_SHORT(ESC_SHORT),
    .ESC_LONG (ESC_LONG)
  ) i_decode (
    .b0    (in_b0),
    .b1    (in_b1),
    .b2    (in_b2),
    .kind  (dec_kind),
    .fields(dec_fields)
  );

  vexp_fault_check #(
    .MAP_LAST(MAP_LAST)
  ) i_fault (
    .kind    (dec_kind),
    .map     (dec_fields.map),
    .pre_66  (pre_66),
    .pre_rep (pre_rep),
    .pre_lock(pre_lock),
    .pre_rex (pre_rex),
    .ud      (dec_ud)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      plen_q   <= 2'd0;
      fields_q <= '0;
      ud_q     <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        plen_q   <= 2'(dec_kind);
        fields_q <= dec_fields;
        ud_q     <= dec_ud;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_plen  = plen_q;
  assign out_r     = fields_q.r;
  assign out_x     = fields_q.x;
  assign out_b     = fields_q.b;
  assign out_map   = fields_q.map;
  assign out_w     = fields_q.w;
  assign out_vreg  = fields_q.vreg;
  assign out_l     = fields_q.l;
  assign out_pp    = fields_q.pp;
  assign out_ud    = ud_q;
endmodule

// File: rtl/vexp_parser_chk.sv
module vexp_parser_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [7:0] in_b0,
  input logic       pre_66,
  input logic       pre_rep,
  input logic       pre_lock,
  input logic       pre_rex,
  input logic       out_valid,
  input logic [1:0] out_plen,
  input logic       out_x,
  input logic       out_b,
  input logic [4:0] out_map,
  input logic       out_w,
  input logic [3:0] out_vreg,
  input logic       out_ud
);
  // R2
  a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid));

  // R3
  a_r3_plain_quiet: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_plen == 2'd0) |-> (!out_ud && out_vreg == 4'd0 && out_map == 5'd0));

  // R4
  a_r4_short_fixed: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_plen == 2'd2) |-> (out_map == 5'd1 && !out_w && !out_x && !out_b));

  // R8
  a_r8_bad_map: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_plen == 2'd3 && (out_map == 5'd0 || out_map > 5'd3)) |-> out_ud);

  // R9
  a_r9_prior_fault: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_b0 == 8'hC4 || in_b0 == 8'hC5) &&
     (pre_66 || pre_rep || pre_lock || pre_rex)) |=> out_ud);

  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_plen) && $stable(out_ud) && $stable(out_vreg) && $stable(out_map)));

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_plen == 2'd0 && !out_ud));
endmodule

bind vexp_parser vexp_parser_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_b0    (in_b0),
  .pre_66   (pre_66),
  .pre_rep  (pre_rep),
  .pre_lock (pre_lock),
  .pre_rex  (pre_rex),
  .out_valid(out_valid),
  .out_plen (out_plen),
  .out_x    (out_x),
  .out_b    (out_b),
  .out_map  (out_map),
  .out_w    (out_w),
  .out_vreg (out_vreg),
  .out_ud   (out_ud)
);

// File: tb/test_vexp_parser.sv
`timescale 1ns/1ps
module test_vexp_parser;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [7:0] in_b0, in_b1, in_b2;
  logic       pre_66, pre_rep, pre_lock, pre_rex;
  logic       out_valid;
  logic [1:0] out_plen;
  logic       out_r, out_x, out_b;
  logic [4:0] out_map;
  logic       out_w;
  logic [3:0] out_vreg;
  logic       out_l;
  logic [1:0] out_pp;
  logic       out_ud;

  always #4 clk = ~clk;

  vexp_parser i_vexp_parser (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_b0(in_b0), .in_b1(in_b1), .in_b2(in_b2),
    .pre_66(pre_66), .pre_rep(pre_rep), .pre_lock(pre_lock), .pre_rex(pre_rex),
    .out_valid(out_valid), .out_plen(out_plen),
    .out_r(out_r), .out_x(out_x), .out_b(out_b),
    .out_map(out_map), .out_w(out_w), .out_vreg(out_vreg),
    .out_l(out_l), .out_pp(out_pp), .out_ud(out_ud)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // expected output state, kept as plain integers
  int e_valid, e_plen, e_r, e_x, e_b, e_map, e_w, e_vreg, e_l, e_pp, e_ud;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compute the expected result for one accepted set of bytes
  task automatic model(input int b0, input int b1, input int b2, input int prior);
    e_plen = 0; e_r = 0; e_x = 0; e_b = 0; e_map = 0; e_w = 0;
    e_vreg = 0; e_l = 0; e_pp = 0; e_ud = 0;
    if (b0 == 'hC5) begin
      e_plen = 2;
      e_r    = ((b1 >> 7) & 1) ^ 1;
      e_map  = 1;
      e_vreg = 15 - ((b1 >> 3) & 15);
      e_l    = (b1 >> 2) & 1;
      e_pp   = b1 & 3;
      e_ud   = prior;
    end else if (b0 == 'hC4) begin
      e_plen = 3;
      e_r    = ((b1 >> 7) & 1) ^ 1;
      e_x    = ((b1 >> 6) & 1) ^ 1;
      e_b    = ((b1 >> 5) & 1) ^ 1;
      e_map  = b1 & 31;
      e_w    = (b2 >> 7) & 1;
      e_vreg = 15 - ((b2 >> 3) & 15);
      e_l    = (b2 >> 2) & 1;
      e_pp   = b2 & 3;
      e_ud   = (prior != 0 || e_map == 0 || e_map > 3) ? 1 : 0;
    end
  endtask

  task automatic compare(input string req);
    chk(req, "valid", out_valid, e_valid);
    chk(req, "plen",  out_plen,  e_plen);
    chk(req, "r",     out_r,     e_r);
    chk(req, "x",     out_x,     e_x);
    chk(req, "b",     out_b,     e_b);
    chk(req, "map",   out_map,   e_map);
    chk(req, "w",     out_w,     e_w);
    chk(req, "vreg",  out_vreg,  e_vreg);
    chk(req, "l",     out_l,     e_l);
    chk(req, "pp",    out_pp,    e_pp);
    chk(req, "ud",    out_ud,    e_ud);
  endtask

  // called at a falling edge: drive, then check at the next falling edge
  task automatic apply(input string req, input bit v, input int b0, input int b1,
                       input int b2, input bit p66, input bit prep, input bit plock,
                       input bit prex);
    in_valid = v; in_b0 = 8'(b0); in_b1 = 8'(b1); in_b2 = 8'(b2);
    pre_66 = p66; pre_rep = prep; pre_lock = plock; pre_rex = prex;
    e_valid = v;
    if (v) model(b0, b1, b2, (p66 | prep | plock | prex) ? 1 : 0);
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b1; in_b0 = 8'hC4; in_b1 = 8'h41; in_b2 = 8'h00;
    pre_66 = 1'b0; pre_rep = 1'b0; pre_lock = 1'b0; pre_rex = 1'b0;
    repeat (3) @(negedge clk);
    e_valid = 0; e_plen = 0; e_r = 0; e_x = 0; e_b = 0; e_map = 0; e_w = 0;
    e_vreg = 0; e_l = 0; e_pp = 0; e_ud = 0;
    compare("R1");
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    compare("R1");

    // R4 R5: short form, all-ones and all-zeros payloads, b2 varied
    apply("R4", 1, 'hC5, 'hFF, 'h00, 0, 0, 0, 0);
    apply("R5", 1, 'hC5, 'h00, 'hFF, 0, 0, 0, 0);
    apply("R5", 1, 'hC5, 'hB6, 'h5A, 0, 0, 0, 0);
    apply("R5", 1, 'hC5, 'hB6, 'hA5, 0, 0, 0, 0);
    // R6 R7: long form
    apply("R6", 1, 'hC4, 'hE1, 'h00, 0, 0, 0, 0);
    apply("R7", 1, 'hC4, 'h02, 'hFF, 0, 0, 0, 0);
    apply("R7", 1, 'hC4, 'h63, 'hB5, 0, 0, 0, 0);
    // R8: every map value
    for (int m = 0; m < 32; m++) apply("R8", 1, 'hC4, 'hE0 | m, 'h78, 0, 0, 0, 0);
    // R9: each prior flag on its own
    for (int f = 0; f < 4; f++) begin
      apply("R9", 1, 'hC4, 'hE1, 'h78, f == 0, f == 1, f == 2, f == 3);
      apply("R9", 1, 'hC5, 'hF8, 'h00, f == 0, f == 1, f == 2, f == 3);
      apply("R3", 1, 'h0F, 'hE1, 'h78, f == 0, f == 1, f == 2, f == 3);
    end
    // R3: ordinary bytes, including near neighbours of the escapes
    apply("R3", 1, 'hC6, 'h00, 'h00, 0, 0, 0, 0);
    apply("R3", 1, 'h62, 'h00, 'hFF, 1, 1, 1, 1);
    // R10: hold while the strobe is low
    apply("R6", 1, 'hC4, 'h42, 'h9D, 0, 0, 0, 0);
    apply("R10", 0, 'hC5, 'h00, 'h00, 1, 0, 0, 0);
    apply("R10", 0, 'h90, 'hFF, 'hFF, 0, 0, 0, 0);
    // R2 and mixed: random traffic with a toggling strobe
    for (int i = 0; i < 400; i++) begin
      int sel;
      int b0;
      sel = $urandom_range(0, 3);
      b0 = (sel == 0) ? 'hC4 : (sel == 1) ? 'hC5 : (sel == 2) ? 'hC4 : $urandom_range(0, 255);
      apply("R2", $urandom_range(0, 3) != 0, b0, $urandom_range(0, 255), $urandom_range(0, 255),
            $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
            $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule